// File: doc/BRIEF.md
# Dual-Mode Host Register Interface

This block gives a host processor access to a small bank of control registers inside a peripheral, over one of two ports. While reset is held it reads the level of the two parallel strobe pins. When both are low, the bank is reached through a serial two-wire port that only ever acts as a target. In every other case an 8-bit parallel port with read and write strobes is used, and the serial engine stays idle. The chosen mode holds until the next reset.

The serial port does not have a fixed device address. It compares incoming address bytes against the low seven bits of register 15, so software can move the device on the bus. A new value written there is applied only once the bus has gone idle after a STOP. Writes use a pointer scheme. The first data byte sets the register pointer, and every byte after it is stored at the pointer, which then steps forward by one. Reads after a repeated START return bytes from the pointer, also stepping forward, until the controller answers with a NACK.

The serial lines pass through a two-flop synchronizer and are oversampled by the system clock, which must run at least 8 times the SCL rate. The block drives SDA only through a low-active open-drain enable.

Top module: `hostreg_if`

## Requirements
- R1: While `rst` is high, `i2c_mode` takes the value 1 if `pp_rd` and `pp_wr` are both 0, and 0 otherwise. After `rst` falls, `i2c_mode` holds whatever the strobes do.
- R2: In parallel mode, a cycle with `pp_wr`=1 stores `pp_wdata` into register `pp_addr`. The new value appears on `regs_o[8*k+7:8*k]` after that clock edge.
- R3: In parallel mode, a cycle with `pp_rd`=1 loads `pp_rdata` with the contents of register `pp_addr` at that clock edge.
- R4: In serial mode, `pp_rd` and `pp_wr` have no effect: no register changes and `pp_rdata` holds its value.
- R5: In parallel mode, `sda_oe` stays 0 whatever SCL and SDA do, including when both are held low.
- R6: An address byte whose upper seven bits differ from the active device address is not acknowledged (SDA reads 1 in the ninth clock). The data bytes that follow are ignored.
- R7: After a matching address with R/W (bit 0) = 0, the target ACKs every byte. The first data byte sets the pointer, and each later byte is written at the pointer, which then increments.
- R8: After a repeated START and a matching address with R/W = 1, the target sends the register at the pointer MSB first, then increments the pointer. It keeps doing so while the controller ACKs and stops after a NACK.
- R9: A serial write to register 15 is stored at once. The active device address changes only after the transaction ends with STOP.
- R10: `sda_oe` changes only while the synchronized SCL is low.
- R11: Reset clears every register to 0 except register 15, which takes `ADDR_RST` (0x2A). It also clears `pp_rdata` and `sda_oe`.
- R12: The register pointer wraps from the last register back to register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset; the strobes are sampled as mode strap while it is high |
| pp_rd | input | 1 | Parallel read strobe, active high |
| pp_wr | input | 1 | Parallel write strobe, active high |
| pp_addr | input | 4 | Parallel register index |
| pp_wdata | input | 8 | Parallel write data |
| pp_rdata | output | 8 | Parallel read data, registered |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | Pull SDA low when 1; SDA is released when 0 |
| i2c_mode | output | 1 | Latched strap: 1 for serial mode, 0 for parallel mode |
| regs_o | output | 128 | All registers flattened, register k in bits 8k+7..8k |

## Verification
The case of interest is a write to the address register and the address comparison landing inside one transaction. The bench writes a new address into register 15 and, with no STOP, issues repeated STARTs: first to the new address, then to the old one. Only the old address may be acknowledged, so the new address must not be live yet. After the STOP the roles swap, and the old address must go unanswered. A second pairing is pointer load and pointer increment. The bench covers it with a write that crosses the top of the bank, where a byte must land at register 15 and the next one at register 0.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WBYTE,
    ST_WACK,
    ST_RBYTE,
    ST_RACK
  } tgt_state_e;
endpackage

// File: rtl/hostreg_sync.sv
module hostreg_sync #(
  parameter int          W      = 2,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] INIT  = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= INIT;
        else     stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= INIT;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hostreg_regfile.sv
module hostreg_regfile #(
  parameter int            NREG      = 16,
  parameter int            DW        = 8,
  parameter int            AW        = $clog2(NREG),
  parameter int            ADDR_REG  = 15,
  parameter logic [DW-1:0] ADDR_INIT = 8'h2A
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [DW-1:0]      wdata,
  input  logic [AW-1:0]      raddr,
  output logic [DW-1:0]      rdata,
  output logic [NREG*DW-1:0] flat
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++)
        mem[i] <= (i == ADDR_REG) ? ADDR_INIT : '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  for (genvar k = 0; k < NREG; k++) begin : g_flat
    assign flat[k*DW +: DW] = mem[k];
  end
endmodule

// File: rtl/hostreg_i2c.sv
module hostreg_i2c
  import hostreg_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic [6:0]    dev_addr,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] ptr_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic          busy_o,
  output logic          sda_oe_o
);
  localparam int CW = $clog2(DW) + 1;

  tgt_state_e    st;
  logic          scl_d, sda_d;
  logic [DW-1:0] sh;
  logic [CW-1:0] cnt;
  logic          rw, ptr_load, nack;

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st       <= ST_IDLE;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
      sh       <= '0;
      cnt      <= '0;
      rw       <= 1'b0;
      ptr_load <= 1'b0;
      nack     <= 1'b0;
      ptr_o    <= '0;
      we_o     <= 1'b0;
      waddr_o  <= '0;
      wdata_o  <= '0;
      busy_o   <= 1'b0;
      sda_oe_o <= 1'b0;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
      we_o  <= 1'b0;
      if (start_c) begin
        st       <= ST_ADDR;
        cnt      <= '0;
        busy_o   <= 1'b1;
        sda_oe_o <= 1'b0;
      end else if (stop_c) begin
        st       <= ST_IDLE;
        busy_o   <= 1'b0;
        sda_oe_o <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[DW-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == CW'(DW)) begin
              if (sh[7:1] == dev_addr) begin
                sda_oe_o <= 1'b1;
                rw       <= sh[0];
                if (!sh[0]) ptr_load <= 1'b1;
                st       <= ST_AACK;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                sh       <= rdata;
                sda_oe_o <= ~rdata[DW-1];
                st       <= ST_RBYTE;
              end else begin
                sda_oe_o <= 1'b0;
                st       <= ST_WBYTE;
              end
            end
          end
          ST_WBYTE: begin
            if (scl_rise) begin
              sh  <= {sh[DW-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == CW'(DW)) begin
              sda_oe_o <= 1'b1;
              st       <= ST_WACK;
              if (ptr_load) begin
                ptr_o    <= sh[AW-1:0];
                ptr_load <= 1'b0;
              end else begin
                we_o    <= 1'b1;
                waddr_o <= ptr_o;
                wdata_o <= sh;
                ptr_o   <= ptr_o + 1'b1;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe_o <= 1'b0;
              cnt      <= '0;
              st       <= ST_WBYTE;
            end
          end
          ST_RBYTE: begin
            if (scl_fall) begin
              if (cnt == CW'(DW - 1)) begin
                sda_oe_o <= 1'b0;
                ptr_o    <= ptr_o + 1'b1;
                st       <= ST_RACK;
              end else begin
                cnt      <= cnt + 1'b1;
                sh       <= {sh[DW-2:0], 1'b0};
                sda_oe_o <= ~sh[DW-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              nack <= sda_s;
            end else if (scl_fall) begin
              if (nack) begin
                st <= ST_IDLE;
              end else begin
                sh       <= rdata;
                sda_oe_o <= ~rdata[DW-1];
                cnt      <= '0;
                st       <= ST_RBYTE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hostreg_if.sv
module hostreg_if #(
  parameter int         NREG     = 16,
  parameter int         DW       = 8,
  parameter int         ADDR_REG = 15,
  parameter logic [6:0] ADDR_RST = 7'h2A,
  parameter int         SYNC_FF  = 2,
  localparam int        AW       = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pp_rd,
  input  logic               pp_wr,
  input  logic [AW-1:0]      pp_addr,
  input  logic [DW-1:0]      pp_wdata,
  output logic [DW-1:0]      pp_rdata,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic               i2c_mode,
  output logic [NREG*DW-1:0] regs_o
);
  logic          scl_s, sda_s;
  logic [6:0]    act_addr;
  logic [AW-1:0] i2c_ptr, i2c_waddr;
  logic          i2c_we, i2c_busy;
  logic [DW-1:0] i2c_wdata, rf_rdata;
  logic          rf_we;
  logic [AW-1:0] rf_waddr, rf_raddr;
  logic [DW-1:0] rf_wdata;

  always_ff @(posedge clk) begin
    if (rst) i2c_mode <= ~pp_rd & ~pp_wr;
  end

  hostreg_sync #(.W(2), .STAGES(SYNC_FF), .INIT(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   ({scl_s, sda_s})
  );

  always_ff @(posedge clk) begin
    if (rst)            act_addr <= ADDR_RST;
    else if (!i2c_busy) act_addr <= regs_o[ADDR_REG*DW +: 7];
  end

  hostreg_i2c #(.AW(AW), .DW(DW)) u_tgt (
    .clk      (clk),
    .rst      (rst),
    .en       (i2c_mode),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .dev_addr (act_addr),
    .rdata    (rf_rdata),
    .ptr_o    (i2c_ptr),
    .we_o     (i2c_we),
    .waddr_o  (i2c_waddr),
    .wdata_o  (i2c_wdata),
    .busy_o   (i2c_busy),
    .sda_oe_o (sda_oe)
  );

  assign rf_we    = i2c_mode ? i2c_we    : pp_wr;
  assign rf_waddr = i2c_mode ? i2c_waddr : pp_addr;
  assign rf_wdata = i2c_mode ? i2c_wdata : pp_wdata;
  assign rf_raddr = i2c_mode ? i2c_ptr   : pp_addr;

  hostreg_regfile #(
    .NREG(NREG), .DW(DW), .AW(AW), .ADDR_REG(ADDR_REG),
    .ADDR_INIT(DW'(ADDR_RST))
  ) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .raddr (rf_raddr),
    .rdata (rf_rdata),
    .flat  (regs_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                   pp_rdata <= '0;
    else if (!i2c_mode && pp_rd) pp_rdata <= rf_rdata;
  end
endmodule

// File: rtl/hostreg_if_chk.sv
module hostreg_if_chk #(
  parameter int NREG = 16,
  parameter int DW   = 8,
  parameter int AW   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               mode,
  input logic               pp_rd,
  input logic               pp_wr,
  input logic [AW-1:0]      pp_addr,
  input logic [DW-1:0]      pp_wdata,
  input logic [DW-1:0]      pp_rdata,
  input logic               sda_oe,
  input logic               scl_s,
  input logic [NREG*DW-1:0] regs
);
  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(mode));

  // R5
  par_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !mode |-> !sda_oe);

  // R4
  strobe_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (mode && pp_rd) |=> $stable(pp_rdata));

  // R2
  par_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode && pp_wr) |=> (regs[$past(pp_addr)*DW +: DW] == $past(pp_wdata)));

  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));
endmodule

bind hostreg_if hostreg_if_chk #(.NREG(NREG), .DW(DW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode     (i2c_mode),
  .pp_rd    (pp_rd),
  .pp_wr    (pp_wr),
  .pp_addr  (pp_addr),
  .pp_wdata (pp_wdata),
  .pp_rdata (pp_rdata),
  .sda_oe   (sda_oe),
  .scl_s    (scl_s),
  .regs     (regs_o)
);

// File: tb/hostreg_if_test.sv
module hostreg_if_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         pp_rd = 1'b0, pp_wr = 1'b0;
  logic [3:0]   pp_addr = '0;
  logic [7:0]   pp_wdata = '0;
  logic [7:0]   pp_rdata;
  logic         scl = 1'b1, msda = 1'b1;
  logic         sda_oe, i2c_mode;
  logic [127:0] regs_o;
  logic         sda_bus;
  logic         oe_bad = 1'b0;
  int           tests = 0, fails = 0;
  string        req_q[$];
  int           val_q[$];

  assign sda_bus = msda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostreg_if uut (
    .clk(clk), .rst(rst), .pp_rd(pp_rd), .pp_wr(pp_wr), .pp_addr(pp_addr),
    .pp_wdata(pp_wdata), .pp_rdata(pp_rdata), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .i2c_mode(i2c_mode), .regs_o(regs_o)
  );

  always @(posedge clk) if (!rst && !i2c_mode && sda_oe) oe_bad <= 1'b1;

  function automatic int rg(int k);
    return int'(regs_o[k*8 +: 8]);
  endfunction

  task automatic expect_item(string r, int v);
    req_q.push_back(r);
    val_q.push_back(v);
  endtask

  task automatic observe(int act);
    string r;
    int    v;
    tests++;
    if (req_q.size() == 0) begin
      fails++;
      $display("FAIL scoreboard empty: actual %0h expected none", act);
    end else begin
      r = req_q.pop_front();
      v = val_q.pop_front();
      if (act != v) begin
        fails++;
        $display("FAIL %s: actual %0h expected %0h", r, act, v);
      end
    end
  endtask

  task automatic chk(string r, int act, int exp);
    expect_item(r, exp);
    observe(act);
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i_start();
    msda = 1'b1; scl = 1'b1; wq();
    msda = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic i_rstart();
    msda = 1'b1; wq();
    scl = 1'b1; wq();
    msda = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic i_stop();
    msda = 1'b0; wq();
    scl = 1'b1; wq();
    msda = 1'b1; wq();
  endtask

  task automatic wbit(logic b);
    msda = b; wq();
    scl = 1'b1; wq();
    scl = 1'b0; wq();
  endtask

  task automatic rbit(output logic b);
    msda = 1'b1; wq();
    scl = 1'b1; repeat (Q/2) @(negedge clk);
    b = sda_bus; repeat (Q/2) @(negedge clk);
    scl = 1'b0; wq();
  endtask

  task automatic wbyte(logic [7:0] v, string r, logic exp_ack);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    expect_item(r, int'(exp_ack));
    rbit(a);
    observe(int'(a));
  endtask

  task automatic rbyte(logic nk, string r, logic [7:0] exp_v);
    logic [7:0] v;
    logic b;
    expect_item(r, int'(exp_v));
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      v[i] = b;
    end
    observe(int'(v));
    wbit(nk);
  endtask

  task automatic do_reset(logic rd, logic wr);
    rst = 1'b1; pp_rd = rd; pp_wr = wr;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    pp_rd = 1'b0; pp_wr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // serial mode
    do_reset(1'b0, 1'b0);
    chk("R1 serial strap", int'(i2c_mode), 1);
    chk("R11 reg15 reset", rg(15), 'h2A);
    chk("R11 reg0 reset", rg(0), 0);
    chk("R11 pp_rdata reset", int'(pp_rdata), 0);
    chk("R11 sda_oe reset", int'(sda_oe), 0);

    // R7 pointer load then burst write
    i_start();
    wbyte(8'h54, "R7 addr ack", 1'b0);
    wbyte(8'h03, "R7 ptr ack", 1'b0);
    wbyte(8'h11, "R7 data ack", 1'b0);
    wbyte(8'h22, "R7 data ack", 1'b0);
    wbyte(8'h33, "R7 data ack", 1'b0);
    i_stop();
    chk("R7 reg3", rg(3), 'h11);
    chk("R7 reg4", rg(4), 'h22);
    chk("R7 reg5", rg(5), 'h33);

    // R8 repeated start read
    i_start();
    wbyte(8'h54, "R8 addr ack", 1'b0);
    wbyte(8'h04, "R8 ptr ack", 1'b0);
    i_rstart();
    wbyte(8'h55, "R8 read addr ack", 1'b0);
    rbyte(1'b0, "R8 first byte", 8'h22);
    rbyte(1'b1, "R8 second byte", 8'h33);
    chk("R8 released after nack", int'(sda_oe), 0);
    i_stop();

    // R6 foreign address ignored
    i_start();
    wbyte(8'h2A, "R6 foreign addr nack", 1'b1);
    wbyte(8'h00, "R6 data nack", 1'b1);
    wbyte(8'hEE, "R6 data nack", 1'b1);
    i_stop();
    chk("R6 reg0 untouched", rg(0), 0);

    // R12 pointer wrap
    i_start();
    wbyte(8'h54, "R12 addr ack", 1'b0);
    wbyte(8'h0E, "R12 ptr ack", 1'b0);
    wbyte(8'h5A, "R12 data ack", 1'b0);
    wbyte(8'h2A, "R12 data ack", 1'b0);
    wbyte(8'h77, "R12 data ack", 1'b0);
    i_stop();
    chk("R12 reg14", rg(14), 'h5A);
    chk("R12 reg0 after wrap", rg(0), 'h77);

    // R9 address change deferred to STOP
    i_start();
    wbyte(8'h54, "R9 addr ack", 1'b0);
    wbyte(8'h0F, "R9 ptr ack", 1'b0);
    wbyte(8'h33, "R9 data ack", 1'b0);
    chk("R9 reg15 stored", rg(15), 'h33);
    i_rstart();
    wbyte(8'h66, "R9 new addr not yet live", 1'b1);
    i_rstart();
    wbyte(8'h54, "R9 old addr still live", 1'b0);
    i_stop();
    wq();
    i_start();
    wbyte(8'h66, "R9 new addr after stop", 1'b0);
    i_stop();
    i_start();
    wbyte(8'h54, "R9 old addr retired", 1'b1);
    i_stop();

    // R4 strobes ignored in serial mode
    pp_addr = 4'h1; pp_wdata = 8'hFF; pp_wr = 1'b1; pp_rd = 1'b1;
    @(negedge clk);
    pp_wr = 1'b0; pp_rd = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 reg1 unchanged", rg(1), 0);
    chk("R4 pp_rdata held", int'(pp_rdata), 0);

    // parallel mode
    do_reset(1'b1, 1'b0);
    chk("R1 parallel strap held", int'(i2c_mode), 0);
    chk("R11 reg15 reset again", rg(15), 'h2A);

    pp_addr = 4'h2; pp_wdata = 8'h5C; pp_wr = 1'b1;
    @(negedge clk);
    pp_wr = 1'b0;
    chk("R2 reg2 write", rg(2), 'h5C);
    pp_addr = 4'h9; pp_wdata = 8'hC3; pp_wr = 1'b1;
    @(negedge clk);
    pp_wr = 1'b0;
    chk("R2 reg9 write", rg(9), 'hC3);

    pp_addr = 4'h2; pp_rd = 1'b1;
    @(negedge clk);
    pp_rd = 1'b0;
    chk("R3 read reg2", int'(pp_rdata), 'h5C);
    pp_addr = 4'h9; pp_rd = 1'b1;
    @(negedge clk);
    pp_rd = 1'b0;
    chk("R3 read reg9", int'(pp_rdata), 'hC3);

    // R5 serial engine idle
    scl = 1'b0; msda = 1'b0;
    repeat (20) @(negedge clk);
    i_start();
    wbyte(8'h54, "R5 no ack in parallel", 1'b1);
    wbyte(8'h00, "R5 no ack in parallel", 1'b1);
    wbyte(8'h99, "R5 no ack in parallel", 1'b1);
    i_stop();
    chk("R5 sda_oe never set", int'(oe_bad), 0);
    chk("R5 reg0 untouched", rg(0), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule